// File: doc/BRIEF.md
# Spectral Correlation Threshold Gate

This block decides, for each pixel of a hyperspectral cube, which of five spectral reconstructions stay close enough to the original spectrum. Band samples stream in one per cycle. Each beat carries the original value and the five reconstructed values for that band. While a pixel streams, the block keeps running sums for every level: the sums of the original and the reconstructed samples, their sums of squares, and the sum of their products.

When the last band of a pixel is accepted, the block forms three mean-corrected terms for each level: the cross term, the original variance term and the reconstructed variance term. Each term has the form N·Σab − Σa·Σb. The block then tests whether the correlation reaches a programmable threshold. It uses neither division nor square root. The cross term is doubled with a one-bit left shift and then squared. The result is compared against the squared threshold multiplied by both variance terms. One pass flag per level is registered in the cycle after the last band. A downstream level selector uses these flags; choosing the level is not part of this block.

Top module: `corr_gate`

## Requirements
- R1: While reset is held and after it is released, `gte` is all zero and `gte_valid` is low until the first pixel completes.
- R2: `gte_valid` is high in exactly the cycle that follows each cycle with `in_valid` and `in_last` both high, and is low in every other cycle.
- R3: Level k (1 to 5) takes its reconstructed sample from `y_in[8k-1:8k-8]` and reports on `gte[k-1]`. `th_sq` is unsigned with 16 fractional bits, so 65536 stands for 1.0. For each level the block forms three terms over the N = `n_bands` samples of the pixel: C = N·Σxy − Σx·Σy, A = N·Σx² − (Σx)² and B = N·Σy² − (Σy)². The flag is high exactly when C ≥ 0 and C²·65536 ≥ `th_sq`·A·B.
- R4: A level whose cross term C is negative reports 0, even when `th_sq` is zero.
- R5: A beat with `in_first` high discards all sums gathered before it, including those of a pixel that never reached its last band. Cycles with `in_valid` low change no sum.
- R6: A level where A or B is zero reports 1. This covers a constant original or reconstructed spectrum, and any single-band pixel.
- R7: The test is inclusive. A reconstruction that is an exact linear image of the original passes at `th_sq` = 65536 and fails at 65537.
- R8: `gte` holds its value in every cycle in which `gte_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A band sample is present this cycle |
| in_first | input | 1 | This sample is the first band of a pixel |
| in_last | input | 1 | This sample is the last band of a pixel |
| x_in | input | 8 | Original spectral sample, unsigned |
| y_in | input | 40 | Five reconstructed samples, level 1 in the low byte |
| n_bands | input | 8 | Band count N of the current pixel |
| th_sq | input | 18 | Squared threshold, unsigned, 16 fractional bits |
| gte | output | 5 | Per-level pass flags |
| gte_valid | output | 1 | Flags were updated this cycle |

## Verification
One pixel holds five very different reconstructions at once: an exact copy, a scaled and offset linear image, a mirrored ramp, a constant and a sparse pattern. This single pixel separates the sign gate, the zero-variance case and the exact-equality case from one another. The same pixel is run at thresholds of 1.0 and just above 1.0, which exposes an off-by-one in the comparison or a wrong fractional alignment. At a zero threshold only the sign of the cross term can clear a flag. Noise of growing amplitude at a threshold of 0.81 shows each level being judged on its own. Idle gaps, an abandoned pixel, single-band pixels and randomized spectra with random band counts check clearing, look-ahead timing and the full arithmetic.

// File: rtl/corr_gate.sv
module corr_gate #(
  parameter int XW   = 8,
  parameter int NW   = 8,
  parameter int LV   = 5,
  parameter int FRAC = 16,
  parameter int THW  = FRAC + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [XW-1:0]    x_in,
  input  logic [LV*XW-1:0] y_in,
  input  logic [NW-1:0]    n_bands,
  input  logic [THW-1:0]   th_sq,
  output logic [LV-1:0]    gte,
  output logic             gte_valid
);
  localparam int SW = XW + NW;
  localparam int QW = 2*XW + NW;
  localparam int TW = QW + NW + 2;
  localparam int DW = TW + 1;
  localparam int CW = 2*DW + FRAC + THW;

  logic [SW-1:0] sx_q;
  logic [QW-1:0] sxx_q;
  logic [SW-1:0] sx_d;
  logic [QW-1:0] sxx_d;
  logic [TW-1:0] txx;
  logic [LV-1:0] neg_d, flat_d, pass_d;

  assign sx_d  = (in_first ? '0 : sx_q)  + SW'(x_in);
  assign sxx_d = (in_first ? '0 : sxx_q) + QW'(x_in) * QW'(x_in);
  assign txx   = TW'(n_bands) * TW'(sxx_d) - TW'(sx_d) * TW'(sx_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sx_q  <= '0;
      sxx_q <= '0;
    end else if (in_valid) begin
      sx_q  <= sx_d;
      sxx_q <= sxx_d;
    end
  end

  for (genvar i = 0; i < LV; i++) begin : g_lv
    logic [XW-1:0] yv;
    logic [SW-1:0] sy_q, sy_d;
    logic [QW-1:0] syy_q, syy_d, sxy_q, sxy_d;
    logic [TW-1:0] txy, tyy;
    logic [DW-1:0] dxy;
    logic [CW-1:0] lhs, rhs;

    assign yv    = y_in[i*XW +: XW];
    assign sy_d  = (in_first ? '0 : sy_q)  + SW'(yv);
    assign syy_d = (in_first ? '0 : syy_q) + QW'(yv) * QW'(yv);
    assign sxy_d = (in_first ? '0 : sxy_q) + QW'(x_in) * QW'(yv);

    assign txy = TW'(n_bands) * TW'(sxy_d) - TW'(sx_d) * TW'(sy_d);
    assign tyy = TW'(n_bands) * TW'(syy_d) - TW'(sy_d) * TW'(sy_d);

    assign dxy = {txy, 1'b0};
    assign lhs = (CW'(dxy) * CW'(dxy)) << (FRAC - 2);
    assign rhs = CW'(th_sq) * CW'(txx) * CW'(tyy);

    assign neg_d[i]  = txy[TW-1];
    assign flat_d[i] = (txx == '0) || (tyy == '0);
    assign pass_d[i] = !neg_d[i] && (flat_d[i] || lhs >= rhs);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sy_q  <= '0;
        syy_q <= '0;
        sxy_q <= '0;
      end else if (in_valid) begin
        sy_q  <= sy_d;
        syy_q <= syy_d;
        sxy_q <= sxy_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gte       <= '0;
      gte_valid <= 1'b0;
    end else begin
      gte_valid <= in_valid && in_last;
      if (in_valid && in_last) gte <= pass_d;
    end
  end
endmodule

// File: rtl/corr_gate_chk.sv
module corr_gate_chk #(
  parameter int LV = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_last,
  input logic [LV-1:0] gte,
  input logic          gte_valid,
  input logic [LV-1:0] neg_d,
  input logic [LV-1:0] flat_d
);
  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last |=> gte_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    gte_valid |-> $past(in_valid && in_last)); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gte_valid |-> $stable(gte)); // R8
  AST_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    gte_valid |-> ((gte & $past(neg_d)) == '0)); // R4
  AST_FLAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    gte_valid |-> ((~gte & $past(flat_d)) == '0)); // R6
endmodule

bind corr_gate corr_gate_chk #(.LV(LV)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .gte(gte), .gte_valid(gte_valid), .neg_d(neg_d), .flat_d(flat_d)
);

// File: tb/corr_gate_tb.sv
module corr_gate_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0]  x_in = 0;
  logic [39:0] y_in = 0;
  logic [7:0]  n_bands = 0;
  logic [17:0] th_sq = 0;
  logic [4:0]  gte;
  logic        gte_valid;

  int checks = 0, failures = 0, hold_err = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] last_seen = 0;
  int px[32];
  int py[5][32];

  always #5 clk = ~clk;

  corr_gate dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .x_in(x_in), .y_in(y_in), .n_bands(n_bands), .th_sq(th_sq),
    .gte(gte), .gte_valid(gte_valid));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input int n, input int th);
    logic [4:0] r;
    for (int l = 0; l < 5; l++) begin
      longint sx = 0, sy = 0, sxx = 0, syy = 0, sxy = 0, a, b, c;
      logic [127:0] lhs, rhs;
      for (int k = 0; k < n; k++) begin
        sx += px[k]; sy += py[l][k];
        sxx += px[k]*px[k]; syy += py[l][k]*py[l][k]; sxy += px[k]*py[l][k];
      end
      c = n*sxy - sx*sy; a = n*sxx - sx*sx; b = n*syy - sy*sy;
      if (c < 0) r[l] = 0;
      else begin
        lhs = (128'(c) * 128'(c)) << 16;
        rhs = 128'(th) * 128'(a) * 128'(b);
        r[l] = lhs >= rhs;
      end
    end
    return r;
  endfunction

  task automatic drive_pixel(input int n, input int th, input bit gaps, input string tag);
    exp_q.push_back(model(n, th));
    tag_q.push_back(tag);
    for (int k = 0; k < n; k++) begin
      if (gaps && k > 0) begin
        @(posedge clk); #1; in_valid = 0; x_in = 8'hFF; y_in = '1;
      end
      @(posedge clk); #1;
      in_valid = 1; in_first = (k == 0); in_last = (k == n-1);
      n_bands = 8'(n); th_sq = 18'(th); x_in = 8'(px[k]);
      for (int l = 0; l < 5; l++) y_in[l*8 +: 8] = 8'(py[l][k]);
    end
    @(posedge clk); #1; in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic drive_partial(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid = 1; in_first = (k == 0); in_last = 0;
      x_in = 8'(250 - 9*k); y_in = {5{8'(7*k + 3)}};
    end
    @(posedge clk); #1; in_valid = 0; in_first = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && gte_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected gte_valid", 1, 0);
      else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(gte === e, t, gte, e);
      end
      last_seen = gte;
    end else if (rst_n && gte !== last_seen) hold_err++;
  end

  initial begin
    #2000000;
    $display("FAIL watchdog R2 actual=running expected=done");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gte === 0 && gte_valid === 0, "R1 reset state", {gte, gte_valid}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(gte === 0 && gte_valid === 0, "R1 after release", {gte, gte_valid}, 0);

    for (int k = 0; k < 16; k++) begin
      px[k] = 10*k + 5;
      py[0][k] = px[k];
      py[1][k] = 5*k + 22;
      py[2][k] = 255 - px[k];
      py[3][k] = 77;
      py[4][k] = (k % 2 == 0) ? px[k] : 0;
    end
    drive_pixel(16, 65536, 0, "R7 R3 R4 R6 mixed at 1.0");
    drive_pixel(16, 65537, 0, "R7 just above 1.0");
    drive_pixel(16, 0, 0, "R4 zero threshold sign gate");

    for (int k = 0; k < 24; k++) begin
      int amp[5] = '{0, 8, 32, 96, 120};
      px[k] = 20 + (k * 37) % 200;
      for (int l = 0; l < 5; l++) begin
        int v = px[k] + ((k * 53 + l * 17) % (2*amp[l] + 1)) - amp[l];
        py[l][k] = v < 0 ? 0 : (v > 255 ? 255 : v);
      end
    end
    drive_pixel(24, 53084, 0, "R3 noise ladder at 0.81");

    drive_partial(5);
    drive_pixel(24, 53084, 1, "R5 abandoned pixel and gaps");

    px[0] = 200;
    for (int l = 0; l < 5; l++) py[l][0] = 13 * l;
    drive_pixel(1, 65537, 0, "R6 single band pixel");
    drive_pixel(1, 0, 0, "R6 single band back to back");

    for (int t = 0; t < 8; t++) begin
      int n = 2 + $urandom_range(30);
      for (int k = 0; k < n; k++) begin
        px[k] = $urandom_range(255);
        for (int l = 0; l < 5; l++)
          py[l][k] = (l < 3) ? (px[k] + $urandom_range(40*l)) % 256 : $urandom_range(255);
      end
      drive_pixel(n, $urandom_range(65536), 0, "R3 random spectrum");
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R2 one result per pixel", exp_q.size(), 0);
    chk(hold_err == 0, "R8 flags hold between pulses", hold_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule